// File: doc/BRIEF.md
# Two-Cycle Command Framer

This block sits between a memory scheduler and a narrow command/address bus. The scheduler hands it abstract requests over a valid/ready port. A request names an operation (read, write, masked write, activate, precharge or refresh), a bank, a row, a column and a burst length of 16 or 32 transfers. The framer turns each request into bus commands, one word per clock at single data rate. Every command spans two clocks. A one-bit select strobe is high during the first clock of the command (the head) and low during the second clock (the tail).

A request that moves data is sent as two commands, so it takes four clocks. The first command carries the operation, the bank, the burst-length flag and the upper column bits. The second command, the column command, follows at once and carries the low column bits. Column bit 0 is always zero and is never put on the bus. A request whose opcode is illegal, or whose column is not aligned to its burst length, is refused. Refusal raises a one-cycle error flag and puts nothing on the bus.

The sequencer has five named states:
- IDLE, where a request is accepted.
- HEAD and TAIL, for the first command.
- COL_HEAD and COL_TAIL, for the column command.

The named transitions are:
- accept: IDLE to HEAD.
- advance: HEAD to TAIL.
- finish: TAIL to IDLE, for non-transfer operations.
- chain: TAIL to COL_HEAD, for transfers.
- advance-col: COL_HEAD to COL_TAIL.
- retire: COL_TAIL to IDLE.
- reject: IDLE back to IDLE, with the error flag set.

Top module: `cmd_framer`

## Requirements
- R1: Every command occupies exactly two clocks. `cmd_cs` is high in the head clock and low in the tail clock. It is never high in two consecutive clocks.
- R2: The head word is {op[5:3], bank[2:0]}. The operation codes are: read 001, write 010, masked write 011, activate 100, precharge 101, refresh 110, column command 111.
- R3: The tail word depends on the operation. For activate it is the 6-bit row. For read, write and masked write it is {burst32 flag at bit 5, col[9:5]}. For precharge and refresh it is all zeros.
- R4: A read, write or masked write is followed directly by a column command. Its head is {111, bank} and its tail is {2'b00, col[4:1]}. Column bit 0 is never sent.
- R5: A transfer is refused when its column is misaligned. With a 16-transfer burst, col[3:0] must be zero. With a 32-transfer burst, col[4:0] must be zero. On refusal, `req_err` is high for one clock, in the clock after the handshake, and the bus stays idle.
- R6: A request with operation code 000 or 111 is refused in the same way as R5.
- R7: The head word appears in the clock after the handshake. `req_ready` is low for 4 clocks after a transfer is accepted and for 2 clocks after any other operation is accepted. The held request is not affected by input changes during that time.
- R8: After reset, and whenever the block is idle, `req_ready` is high, `cmd_cs` is low, `cmd_ca` is zero and `req_err` is low.
- R9: Activate, precharge and refresh ignore the column and burst fields. A misaligned column on these operations causes no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The framer can accept a request |
| req_op | input | 3 | Operation code (R2 encoding) |
| req_bank | input | BANK_W | Bank number |
| req_row | input | BANK_W+3 | Row for activate |
| req_col | input | COL_W | Column address |
| req_bl32 | input | 1 | 1 selects a 32-transfer burst, 0 a 16-transfer burst |
| req_err | output | 1 | One-clock pulse when a request is refused |
| cmd_cs | output | 1 | Command select strobe, active high |
| cmd_ca | output | BANK_W+3 | Command/address word |

## Verification
Some properties are checked by assertions on every clock:
- The strobe is never high twice in a row.
- An idle framer keeps the bus quiet.
- A refusal never coincides with bus activity.
- Ready only falls after a request was offered.
- A transfer head is always followed two clocks later by a column-command head.
- A column command never appears without a transfer head two clocks before it.

Other behaviours can only be shown by the directed scenarios, because they need the request's field values to work out the expected words:
- The exact head and tail contents.
- The alignment decision for each burst length.
- Refusal of illegal opcodes.
- Ready staying low for four clocks or two.
- The held request staying unaffected by input changes while the framer is busy.

// File: rtl/cmdfr_pkg.sv
package cmdfr_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_NONE   = 3'd0,
        OP_READ   = 3'd1,
        OP_WRITE  = 3'd2,
        OP_MWRITE = 3'd3,
        OP_ACT    = 3'd4,
        OP_PRE    = 3'd5,
        OP_REF    = 3'd6,
        OP_CAS    = 3'd7
    } cmd_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEAD,
        ST_TAIL,
        ST_COL_HEAD,
        ST_COL_TAIL
    } seq_state_e;

    function automatic logic op_is_xfer(input logic [OP_W-1:0] op);
        return (op == OP_READ) || (op == OP_WRITE) || (op == OP_MWRITE);
    endfunction

    function automatic logic op_is_legal(input logic [OP_W-1:0] op);
        return (op != OP_NONE) && (op != OP_CAS);
    endfunction

endpackage

// File: rtl/cmdfr_check.sv
module cmdfr_check
    import cmdfr_pkg::*;
#(
    parameter int COL_W  = 10,
    parameter int BL_LG  = 4
) (
    input  logic [OP_W-1:0]  op,
    input  logic [COL_W-1:0] col,
    input  logic             bl32,
    output logic             xfer,
    output logic             ok
);

    localparam logic [COL_W-1:0] SHORT_MASK = COL_W'((1 << BL_LG) - 1);
    localparam logic [COL_W-1:0] LONG_MASK  = COL_W'((1 << (BL_LG + 1)) - 1);

    logic aligned;

    always_comb begin
        xfer    = op_is_xfer(op);
        aligned = bl32 ? ((col & LONG_MASK) == '0) : ((col & SHORT_MASK) == '0);
        ok      = op_is_legal(op) && (!xfer || aligned);
    end

endmodule

// File: rtl/cmdfr_seq.sv
module cmdfr_seq
    import cmdfr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_ok,
    input  logic       hold_xfer,
    output seq_state_e state_q,
    output logic       req_ready,
    output logic       load,
    output logic       req_err
);

    seq_state_e state_d;
    logic       take;

    always_comb begin
        req_ready = (state_q == ST_IDLE);
        take      = req_valid && req_ready;
        load      = take && req_ok;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     state_d = load ? ST_HEAD : ST_IDLE;
            ST_HEAD:     state_d = ST_TAIL;
            ST_TAIL:     state_d = hold_xfer ? ST_COL_HEAD : ST_IDLE;
            ST_COL_HEAD: state_d = ST_COL_TAIL;
            ST_COL_TAIL: state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_err <= 1'b0;
        end else begin
            req_err <= take && !req_ok;
        end
    end

    AST_READY_FALLS_ON_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_ready) |-> $past(req_valid)); // R7

    AST_REFUSE_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> (state_q == ST_IDLE)); // R5

endmodule

// File: rtl/cmdfr_encode.sv
module cmdfr_encode
    import cmdfr_pkg::*;
#(
    parameter int BANK_W = 3,
    parameter int HI_W   = 5,
    parameter int LOW_W  = 4
) (
    input  seq_state_e                state_q,
    input  cmd_op_e                   op,
    input  logic [BANK_W-1:0]         bank,
    input  logic [OP_W+BANK_W-1:0]    row,
    input  logic [HI_W-1:0]           col_hi,
    input  logic [LOW_W-1:0]          col_lo,
    input  logic                      bl32,
    output logic                      cs,
    output logic [OP_W+BANK_W-1:0]    ca
);

    localparam int CA_W = OP_W + BANK_W;

    always_comb begin
        cs = 1'b0;
        ca = '0;
        unique case (state_q)
            ST_IDLE: begin
                cs = 1'b0;
                ca = '0;
            end
            ST_HEAD: begin
                cs = 1'b1;
                ca = {op, bank};
            end
            ST_TAIL: begin
                cs = 1'b0;
                if (op == OP_ACT) begin
                    ca = row;
                end else if (op_is_xfer(op)) begin
                    ca = {bl32, col_hi};
                end else begin
                    ca = '0;
                end
            end
            ST_COL_HEAD: begin
                cs = 1'b1;
                ca = {OP_CAS, bank};
            end
            ST_COL_TAIL: begin
                cs = 1'b0;
                ca = {{(CA_W - LOW_W){1'b0}}, col_lo};
            end
            default: begin
                cs = 1'b0;
                ca = '0;
            end
        endcase
    end

endmodule

// File: rtl/cmd_framer.sv
module cmd_framer
    import cmdfr_pkg::*;
#(
    parameter int BANK_W = 3,
    parameter int COL_W  = 10,
    parameter int BL_LG  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [2:0]          req_op,
    input  logic [BANK_W-1:0]   req_bank,
    input  logic [BANK_W+2:0]   req_row,
    input  logic [COL_W-1:0]    req_col,
    input  logic                req_bl32,
    output logic                req_err,
    output logic                cmd_cs,
    output logic [BANK_W+2:0]   cmd_ca
);

    localparam int CA_W  = OP_W + BANK_W;
    localparam int LOW_W = BL_LG;
    localparam int HI_W  = COL_W - 1 - LOW_W;

    seq_state_e             state_q;
    logic                   req_ok;
    logic                   req_xfer;
    logic                   load;
    cmd_op_e                hold_op;
    logic [BANK_W-1:0]      hold_bank;
    logic [CA_W-1:0]        hold_row;
    logic [COL_W-1:1]       hold_col;
    logic                   hold_bl32;
    logic                   hold_xfer;

    cmdfr_check #(
        .COL_W (COL_W),
        .BL_LG (BL_LG)
    ) check_i (
        .op   (req_op),
        .col  (req_col),
        .bl32 (req_bl32),
        .xfer (req_xfer),
        .ok   (req_ok)
    );

    cmdfr_seq seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ok    (req_ok),
        .hold_xfer (hold_xfer),
        .state_q   (state_q),
        .req_ready (req_ready),
        .load      (load),
        .req_err   (req_err)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_op   <= OP_NONE;
            hold_bank <= '0;
            hold_row  <= '0;
            hold_col  <= '0;
            hold_bl32 <= 1'b0;
            hold_xfer <= 1'b0;
        end else if (load) begin
            hold_op   <= cmd_op_e'(req_op);
            hold_bank <= req_bank;
            hold_row  <= req_row;
            hold_col  <= req_col[COL_W-1:1];
            hold_bl32 <= req_bl32;
            hold_xfer <= req_xfer;
        end
    end

    cmdfr_encode #(
        .BANK_W (BANK_W),
        .HI_W   (HI_W),
        .LOW_W  (LOW_W)
    ) encode_i (
        .state_q (state_q),
        .op      (hold_op),
        .bank    (hold_bank),
        .row     (hold_row),
        .col_hi  (hold_col[COL_W-1:LOW_W+1]),
        .col_lo  (hold_col[LOW_W:1]),
        .bl32    (hold_bl32),
        .cs      (cmd_cs),
        .ca      (cmd_ca)
    );

    AST_CS_SINGLE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_cs |=> !cmd_cs); // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!cmd_cs && cmd_ca == '0)); // R8

    AST_REFUSE_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> (!cmd_cs && req_ready)); // R5

    AST_COL_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_cs && op_is_xfer(cmd_ca[CA_W-1 -: OP_W]))
        |-> ##2 (cmd_cs && cmd_ca[CA_W-1 -: OP_W] == OP_CAS)); // R4

    AST_COL_NEEDS_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_cs && cmd_ca[CA_W-1 -: OP_W] == OP_CAS)
        |-> ($past(cmd_cs, 2) && op_is_xfer($past(cmd_ca[CA_W-1 -: OP_W], 2)))); // R4

endmodule

// File: tb/cmd_framer_tb_top.sv
module cmd_framer_tb_top;

    logic       clk;
    logic       rst_n;
    logic       req_valid;
    logic       req_ready;
    logic [2:0] req_op;
    logic [2:0] req_bank;
    logic [5:0] req_row;
    logic [9:0] req_col;
    logic       req_bl32;
    logic       req_err;
    logic       cmd_cs;
    logic [5:0] cmd_ca;

    int n_cmp = 0;
    int n_bad = 0;

    cmd_framer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_op    (req_op),
        .req_bank  (req_bank),
        .req_row   (req_row),
        .req_col   (req_col),
        .req_bl32  (req_bl32),
        .req_err   (req_err),
        .cmd_cs    (cmd_cs),
        .cmd_ca    (cmd_ca)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    function automatic logic [8:0] bus_now();
        return {req_ready, req_err, cmd_cs, cmd_ca};
    endfunction

    task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%03h expected=%03h", tag, act, exp);
        end
    endtask

    function automatic logic exp_ok(input logic [2:0] op, input logic [9:0] col, input logic bl32);
        logic xfer;
        logic aligned;
        xfer    = (op == 3'd1) || (op == 3'd2) || (op == 3'd3);
        aligned = bl32 ? (col[4:0] == 5'd0) : (col[3:0] == 4'd0);
        return (op != 3'd0) && (op != 3'd7) && (!xfer || aligned);
    endfunction

    // Drive one request at the current negedge and check every bus clock.
    task automatic issue(input string tag, input logic [2:0] op, input logic [2:0] bank,
                         input logic [5:0] row, input logic [9:0] col, input logic bl32);
        logic       xfer;
        logic [5:0] tail;
        xfer = (op == 3'd1) || (op == 3'd2) || (op == 3'd3);
        if (op == 3'd4)  tail = row;
        else if (xfer)   tail = {bl32, col[9:5]};
        else             tail = 6'd0;
        req_valid = 1'b1;
        req_op    = op;
        req_bank  = bank;
        req_row   = row;
        req_col   = col;
        req_bl32  = bl32;
        @(negedge clk);
        req_valid = 1'b0;
        req_row   = ~row;
        req_col   = ~col;
        req_bank  = ~bank;
        req_bl32  = ~bl32;
        if (!exp_ok(op, col, bl32)) begin
            chk({tag, " R5/R6 refusal pulse"}, bus_now(), {1'b1, 1'b1, 1'b0, 6'd0});
            @(negedge clk);
            chk({tag, " R5/R6 refusal quiet"}, bus_now(), {1'b1, 1'b0, 1'b0, 6'd0});
            return;
        end
        chk({tag, " R1/R2/R7 head"}, bus_now(), {1'b0, 1'b0, 1'b1, op, bank});
        @(negedge clk);
        chk({tag, " R1/R3 tail"}, bus_now(), {1'b0, 1'b0, 1'b0, tail});
        if (xfer) begin
            @(negedge clk);
            chk({tag, " R4 col head"}, bus_now(), {1'b0, 1'b0, 1'b1, 3'b111, bank});
            @(negedge clk);
            chk({tag, " R4 col tail"}, bus_now(), {1'b0, 1'b0, 1'b0, 2'b00, col[4:1]});
        end
        @(negedge clk);
        chk({tag, " R7/R8 idle after"}, bus_now(), {1'b1, 1'b0, 1'b0, 6'd0});
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 in reset", bus_now(), {1'b1, 1'b0, 1'b0, 6'd0});
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 after reset", bus_now(), {1'b1, 1'b0, 1'b0, 6'd0});
    endtask

    task automatic t_transfers();
        issue("R2 read bl16", 3'd1, 3'd5, 6'd0, 10'b1011010000, 1'b0);
        issue("R3 write bl32", 3'd2, 3'd2, 6'd0, 10'b1101100000, 1'b1);
        issue("R4 mwrite bl16", 3'd3, 3'd7, 6'd0, 10'b0000110000, 1'b0);
    endtask

    task automatic t_plain();
        issue("R3 activate", 3'd4, 3'd3, 6'b101101, 10'd0, 1'b0);
        issue("R3 precharge", 3'd5, 3'd6, 6'b111111, 10'd0, 1'b1);
        issue("R3 refresh", 3'd6, 3'd1, 6'b010101, 10'd0, 1'b0);
    endtask

    task automatic t_refuse();
        issue("R5 bl16 misaligned", 3'd1, 3'd4, 6'd0, 10'b0000000100, 1'b0);
        issue("R5 bl32 misaligned", 3'd2, 3'd4, 6'd0, 10'b0000010000, 1'b1);
        issue("R5 bit0 set", 3'd3, 3'd0, 6'd0, 10'b1000000001, 1'b0);
        issue("R6 op 000", 3'd0, 3'd2, 6'd0, 10'd0, 1'b0);
        issue("R6 op 111", 3'd7, 3'd2, 6'd0, 10'd0, 1'b0);
    endtask

    task automatic t_ignore_col();
        issue("R9 activate odd col", 3'd4, 3'd2, 6'b000111, 10'b0101010101, 1'b1);
        issue("R9 refresh odd col", 3'd6, 3'd0, 6'd0, 10'b0000000011, 1'b0);
    endtask

    task automatic t_back_to_back();
        req_valid = 1'b1;
        req_op    = 3'd1;
        req_bank  = 3'd6;
        req_row   = 6'd0;
        req_col   = 10'b0100100000;
        req_bl32  = 1'b1;
        @(negedge clk);
        req_op   = 3'd4;
        req_bank = 3'd1;
        req_row  = 6'b110011;
        req_col  = 10'd0;
        req_bl32 = 1'b0;
        chk("R7 b2b head1", bus_now(), {1'b0, 1'b0, 1'b1, 3'd1, 3'd6});
        @(negedge clk);
        chk("R7 b2b tail1", bus_now(), {1'b0, 1'b0, 1'b0, 1'b1, 5'b01001});
        @(negedge clk);
        chk("R7 b2b col head", bus_now(), {1'b0, 1'b0, 1'b1, 3'b111, 3'd6});
        @(negedge clk);
        chk("R7 b2b col tail", bus_now(), {1'b0, 1'b0, 1'b0, 6'd0});
        @(negedge clk);
        chk("R7 b2b idle gap", bus_now(), {1'b1, 1'b0, 1'b0, 6'd0});
        @(negedge clk);
        req_valid = 1'b0;
        chk("R7 b2b head2", bus_now(), {1'b0, 1'b0, 1'b1, 3'd4, 3'd1});
        @(negedge clk);
        chk("R7 b2b tail2", bus_now(), {1'b0, 1'b0, 1'b0, 6'b110011});
        @(negedge clk);
        chk("R8 b2b idle end", bus_now(), {1'b1, 1'b0, 1'b0, 6'd0});
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R7 watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_op    = 3'd0;
        req_bank  = 3'd0;
        req_row   = 6'd0;
        req_col   = 10'd0;
        req_bl32  = 1'b0;
        @(negedge clk);
        t_reset();
        t_transfers();
        t_plain();
        t_refuse();
        t_ignore_col();
        t_back_to_back();
        repeat (2) @(negedge clk);
        summary();
    end

endmodule